// File: doc/BRIEF.md
# Timer Channel Pin Controller

This block owns the one I/O pin of a general-purpose timer channel. Software programs it through two words: a control word that says what the pin is for and how it behaves, and a status word that returns the live pin level and holds the sticky event flags. The counter and prescaler datapath sit elsewhere; this block only decodes the compare and PWM selections so that it does not drive the pin in those modes.

As a plain port, the pin can be driven low, driven high, or left floating as an input. An open-drain option turns a driven high into a released pin. As a capture input, the synchronized pin is watched for rising edges, falling edges or both. A chosen edge sets a flag that stays set until software writes a one to it, and the flags can raise a registered interrupt line when the enable bit is set.

Top module: `tpin_unit`

## Requirements
- R1: After reset the control word reads 0, every event flag is 0, `pin_oe` is 0 and `irq` is 0.
- R2: The control word holds the select field in bits 2:0 (0 off, 1 capture, 2 compare, 3 PWM, 4 port), the drive field in bits 5:4, the interrupt enable in bit 8, the open-drain bit in bit 9 and the edge field in bits 17:16. Every other bit reads as 0. `reg_wr_sel`/`reg_rd_sel` value 0 addresses the control word and 1 the status word.
- R3: With select 4, a drive field of 2'b10 drives the pin low and 2'b11 drives it high (`pin_oe`=1, `pin_out` equal to drive bit 4); 2'b00 and 2'b01 leave `pin_oe` at 0.
- R4: With the open-drain bit set, a high drive leaves `pin_oe` at 0, while a low drive still drives the pin low.
- R5: For any select value other than 4, `pin_oe` is 0 whatever the drive field holds, and `pin_out` is 0 whenever `pin_oe` is 0.
- R6: Status bit 8 gives the pin level after a two-flop synchronizer: a change made just after a clock edge is not visible after the next edge and is visible after the second.
- R7: Only with select 1, an edge field of 2'b01 makes a synchronized rising edge set status bit 0, 2'b10 a falling edge, 2'b11 either edge; 2'b00 and all other selects set no flag. Status bits 3:1 are never set here and read 0.
- R8: Writing the status word clears each flag whose data bit is 1; data bits that are 0 leave flags unchanged.
- R9: When an edge sets a flag in the same cycle that a write clears it, the flag ends up set.
- R10: `irq` is 1 one cycle after both the interrupt enable and at least one flag are 1; with the enable clear it stays 0 while flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the selected word |
| reg_wr_sel | input | 1 | Write target: 0 control, 1 status (clear by ones) |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_sel | input | 1 | Read target: 0 control, 1 status |
| reg_rd_data | output | DATA_W | Read data of the selected word |
| pin_in | input | 1 | Asynchronous level seen on the pin |
| pin_out | output | 1 | Level driven on the pin when enabled |
| pin_oe | output | 1 | Pin driver enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The drive path is tried with all four drive codes under the port select, then the same codes under compare, PWM and unused selects, and with open drain on and off, which separates the select gate from the open-drain release. Capture is tried with each edge code against both pin directions, so a rising-only detector is told apart from a both-edge or falling one, and with capture off to show the gate. Clears are tried with ones and with zeros, and once landing in the very cycle an edge arrives to expose a clear-over-set priority. The readback is sampled one and two edges after a pin change to pin down the synchronizer depth.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

    // Select field codes (control word bits 2:0)
    localparam logic [2:0] SEL_OFF     = 3'd0;
    localparam logic [2:0] SEL_CAPTURE = 3'd1;
    localparam logic [2:0] SEL_COMPARE = 3'd2;
    localparam logic [2:0] SEL_PWM     = 3'd3;
    localparam logic [2:0] SEL_PORT    = 3'd4;

    // Field positions in the control word
    localparam int SEL_LSB   = 0;
    localparam int DRV_LSB   = 4;
    localparam int IEN_BIT   = 8;
    localparam int OD_BIT    = 9;
    localparam int EDGE_LSB  = 16;
    localparam int CTRL_BITS = 18;

    // Position of the level readback in the status word
    localparam int LEVEL_BIT = 8;

    typedef struct packed {
        logic [1:0] edge_sel;
        logic       open_drain;
        logic       irq_en;
        logic [1:0] drive;
        logic [2:0] sel;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_BITS-1:0] w);
        ctrl_t c;
        c.sel        = w[SEL_LSB +: 3];
        c.drive      = w[DRV_LSB +: 2];
        c.irq_en     = w[IEN_BIT];
        c.open_drain = w[OD_BIT];
        c.edge_sel   = w[EDGE_LSB +: 2];
        return c;
    endfunction

    function automatic logic [CTRL_BITS-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_BITS-1:0] w;
        w = '0;
        w[SEL_LSB +: 3]  = c.sel;
        w[DRV_LSB +: 2]  = c.drive;
        w[IEN_BIT]       = c.irq_en;
        w[OD_BIT]        = c.open_drain;
        w[EDGE_LSB +: 2] = c.edge_sel;
        return w;
    endfunction

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1; // synchronizer plus one history flop

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = pin_async;
        for (int i = 1; i < CHAIN_W; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level = chain_q[STAGES-1];
    assign rise  =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall  = ~chain_q[STAGES-1] &  chain_q[STAGES];

    // R6: the readback only moves to a value the pin held an edge earlier
    p_level_from_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (level == $past(chain_q[STAGES-2])));

endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
    import tpin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctrl_t ctrl,
    output logic pin_out,
    output logic pin_oe
);
    logic port_mode;
    logic drive_on;

    always_comb begin
        port_mode = (ctrl.sel == SEL_PORT);
        drive_on  = port_mode && ctrl.drive[1];
        // open drain: a high level releases the pin
        pin_oe    = drive_on && !(ctrl.open_drain && ctrl.drive[0]);
        pin_out   = pin_oe && ctrl.drive[0];
    end

    // R5: only the port select may enable the driver
    p_oe_only_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (ctrl.sel == SEL_PORT));

    // R4: with open drain a driven pin is always low
    p_od_low_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && ctrl.open_drain) |-> !pin_out);

    // R5: an undriven pin carries no level
    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);

endmodule

// File: rtl/tpin_capture.sv
module tpin_capture #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_on,
    input  logic [1:0]        edge_sel,
    input  logic              rise,
    input  logic              fall,
    input  logic              clr_en,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic              irq_en,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              irq;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       hit;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;

    always_comb begin
        hit     = capture_on && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
        set_vec = '0;
        set_vec[0] = hit;
        clr_vec = clr_en ? clr_mask : '0;
        st_d.flags = (st_q.flags & ~clr_vec) | set_vec; // set wins over clear
        st_d.irq   = irq_en && (|st_q.flags);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign irq   = st_q.irq;

    // R9: a capture event in a clearing cycle leaves the flag set
    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_en && clr_mask[0]) |=> flags[0]);

    // R8: a clear with no event empties the flag
    p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && clr_en && clr_mask[0]) |=> !flags[0]);

    // R7: flags appear only while capture is selected
    p_flag_needs_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(capture_on));

    // R7: upper flags are never set by this block
    p_upper_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_W-1:1] == '0);

endmodule

// File: rtl/tpin_unit.sv
module tpin_unit
    import tpin_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FLAG_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              reg_rd_sel,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);
    typedef struct packed {
        ctrl_t ctrl;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic              level, rise, fall;
    logic [FLAG_W-1:0] flags;
    logic              clr_en;
    logic [FLAG_W-1:0] clr_mask;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        st_d = st_q;
        if (reg_wr_en && !reg_wr_sel) begin
            st_d.ctrl = ctrl_unpack(reg_wr_data[CTRL_BITS-1:0]);
        end
        clr_en   = reg_wr_en && reg_wr_sel;
        clr_mask = reg_wr_data[FLAG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(pin_in),
        .level    (level),
        .rise     (rise),
        .fall     (fall)
    );

    tpin_drive u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (st_q.ctrl),
        .pin_out(pin_out),
        .pin_oe (pin_oe)
    );

    tpin_capture #(.FLAG_W(FLAG_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_on(st_q.ctrl.sel == SEL_CAPTURE),
        .edge_sel  (st_q.ctrl.edge_sel),
        .rise      (rise),
        .fall      (fall),
        .clr_en    (clr_en),
        .clr_mask  (clr_mask),
        .irq_en    (st_q.ctrl.irq_en),
        .flags     (flags),
        .irq       (irq)
    );

    always_comb begin
        status_word = '0;
        status_word[FLAG_W-1:0] = flags;
        status_word[LEVEL_BIT]  = level;
        ctrl_word = '0;
        ctrl_word[CTRL_BITS-1:0] = ctrl_pack(st_q.ctrl);
        reg_rd_data = reg_rd_sel ? status_word : ctrl_word;
    end

    // R10: a request needs the enable one cycle earlier
    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_q.ctrl.irq_en));

    // R10: a request needs a pending flag one cycle earlier
    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|flags));

endmodule

// File: tb/tpin_unit_test.sv
module tpin_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic              reg_wr_sel = 1'b0;
    logic [DATA_W-1:0] reg_wr_data = '0;
    logic              reg_rd_sel = 1'b0;
    logic [DATA_W-1:0] reg_rd_data;
    logic              pin_in = 1'b0;
    logic              pin_out, pin_oe, irq;

    tpin_unit #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // kind: 0 read data, 1 pin_oe, 2 pin_out, 3 irq
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int pushed = 0;
    int done = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = reg_rd_data;
                    1: act = {31'd0, pin_oe};
                    2: act = {31'd0, pin_out};
                    default: act = {31'd0, irq};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
                done++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input int kind, input logic [31:0] v, input string tag);
        item_t it;
        it.kind = kind; it.exp = v; it.tag = tag;
        q.push_back(it);
        pushed++;
        wait (done == pushed);
    endtask

    task automatic expect_rd(input bit sel, input logic [31:0] v, input string tag);
        reg_rd_sel = sel;
        expect_item(0, v, tag);
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    task automatic drive_pin(input logic v);
        @(posedge clk); #1;
        pin_in = v;
        tick(4);
    endtask

    task automatic expect_drive(input logic oe, input logic o, input string tag);
        expect_item(1, {31'd0, oe}, tag);
        expect_item(2, {31'd0, o}, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        expect_rd(0, 32'h0, "R1 control after reset");
        expect_rd(1, 32'h0, "R1 status after reset");
        expect_item(1, 32'h0, "R1 oe after reset");
        expect_item(3, 32'h0, "R1 irq after reset");

        // R3 port drive codes
        wr(0, 32'h0000_0034); expect_drive(1, 1, "R3 drive high");
        wr(0, 32'h0000_0024); expect_drive(1, 0, "R3 drive low");
        wr(0, 32'h0000_0014); expect_drive(0, 0, "R3 code 01 input");
        wr(0, 32'h0000_0004); expect_drive(0, 0, "R3 code 00 input");

        // R2 field layout and unused bits
        wr(0, 32'hFFFF_FFFF);
        expect_rd(0, 32'h0003_0337, "R2 all-ones readback");
        // R5 select 7 with drive high
        expect_drive(0, 0, "R5 select 7");
        wr(0, 32'h0000_0032); expect_drive(0, 0, "R5 compare select");
        wr(0, 32'h0000_0033); expect_drive(0, 0, "R5 pwm select");
        wr(0, 32'h0000_0031); expect_drive(0, 0, "R5 capture select");

        // R4 open drain
        wr(0, 32'h0000_0234); expect_drive(0, 0, "R4 od high released");
        wr(0, 32'h0000_0224); expect_drive(1, 0, "R4 od low driven");

        // R6 synchronizer depth
        wr(0, 32'h0);
        @(posedge clk); #1; pin_in = 1'b1;
        tick(1);
        expect_rd(1, 32'h0000_0000, "R6 level after one edge");
        tick(1);
        expect_rd(1, 32'h0000_0100, "R6 level after two edges");

        // R7 rising select
        drive_pin(1'b0);
        wr(0, 32'h0001_0001);
        drive_pin(1'b1);
        expect_rd(1, 32'h0000_0101, "R7 rising edge flags");
        // R10 masked while enable clear
        expect_item(3, 32'h0, "R10 irq masked");
        // R8 clear by ones
        wr(1, 32'h0000_000F);
        tick(1);
        expect_rd(1, 32'h0000_0100, "R8 clear with ones");
        drive_pin(1'b0);
        expect_rd(1, 32'h0000_0000, "R7 falling ignored under rising select");

        // R7 falling select
        wr(0, 32'h0002_0001);
        drive_pin(1'b1);
        expect_rd(1, 32'h0000_0100, "R7 rising ignored under falling select");
        drive_pin(1'b0);
        expect_rd(1, 32'h0000_0001, "R7 falling edge flags");
        // R8 zeros have no effect
        wr(1, 32'h0000_0000);
        tick(1);
        expect_rd(1, 32'h0000_0001, "R8 zeros keep flag");

        // R10 enable with pending flag
        wr(0, 32'h0002_0101);
        tick(1);
        expect_item(3, 32'h1, "R10 irq raised");
        wr(1, 32'h0000_0001);
        tick(2);
        expect_item(3, 32'h0, "R10 irq dropped after clear");

        // R7 both edges
        wr(0, 32'h0003_0001);
        drive_pin(1'b1);
        expect_rd(1, 32'h0000_0101, "R7 both: rising");
        wr(1, 32'h0000_0001);
        drive_pin(1'b0);
        expect_rd(1, 32'h0000_0001, "R7 both: falling");

        // R9 set in the clearing cycle (flag already set, pin high->low event)
        drive_pin(1'b1);
        @(posedge clk); #1; pin_in = 1'b0;
        tick(1);
        wr(1, 32'h0000_0001);
        tick(2);
        expect_rd(1, 32'h0000_0001, "R9 set wins over clear");
        wr(1, 32'h0000_0001);
        tick(1);
        expect_rd(1, 32'h0000_0000, "R8 plain clear");

        // R7 edge code 00 and non-capture select
        wr(0, 32'h0000_0001);
        drive_pin(1'b1);
        drive_pin(1'b0);
        expect_rd(1, 32'h0000_0000, "R7 edge code 00 no flag");
        wr(0, 32'h0003_0004);
        drive_pin(1'b1);
        drive_pin(1'b0);
        expect_rd(1, 32'h0000_0000, "R7 port select no flag");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule